// File: doc/BRIEF.md
# Read-Protection Command Access Gate

This block decides whether in-system-programming commands may run, based on a protection word kept in flash. The first clock edge after the power-on reset is released captures the 32-bit word and decodes it into one of four protection levels. The captured level then stays fixed until reset is asserted again, so later writes to the word have no effect until the next power cycle.

Each command request carries an opcode, a target address, a target sector, a flag that says all sectors are selected, and a flag that marks the command as issued by the running application. One cycle after the request, the block returns a response with an allow bit. It also drives a debug-port disable output and an output that permits entry into programming mode from the boot-select pin. The flash controller, the command parser and the debug port itself sit outside this block.

Top module: `crp_cmd_gate`

## Requirements
- R1: On the first rising clock edge with `rst` low, `prot_word` is captured. 0x12345678 gives level 1, 0x87654321 gives level 2, 0x43218765 gives level 3, and any other value gives level 0 (open). `level_o` shows the level as 0 to 3.
- R2: After capture, changes on `prot_word` do not change the level until `rst` is asserted again. A new reset followed by release captures the word again.
- R3: `debug_disable` is high during reset, until the capture edge, and whenever the level is 1, 2 or 3. It is low only when the captured level is 0.
- R4: Each cycle with `req_valid` high produces exactly one cycle with `resp_valid` high one cycle later. `resp_allow` is low whenever `resp_valid` is low.
- R5: A request presented before the capture edge has happened (including in the capture cycle itself) is denied.
- R6: At level 1, write-RAM (opcode 1) is denied when `req_addr` < 0x40000200 and allowed at or above that address.
- R7: At level 1, copy-to-flash (opcode 3) is denied when `req_sector` is 0 and allowed for any other sector.
- R8: At level 1, erase (opcode 5) of sector 0 is allowed only when `req_all_sectors` is high, and erase of any other sector is allowed. Read (opcode 0) and compare (opcode 4) are denied, and go (opcode 2) is allowed.
- R9: At level 2, read, write-RAM, go, copy-to-flash and compare (opcodes 0 to 4) are denied. Erase is allowed only when `req_all_sectors` is high.
- R10: `isp_entry` is high when `boot_sel_n` is low and the capture has happened, unless the level is 3 and `user_code_valid` is high.
- R11: Once the capture has happened, these requests are allowed: requests with `req_from_app` high, opcodes 6 and 7 (other), and every request at levels 0 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| prot_word | input | 32 | Protection word read from flash offset 0x1FC |
| req_valid | input | 1 | One-cycle command request strobe |
| req_op | input | 3 | Command opcode |
| req_addr | input | 32 | Target address of the command |
| req_sector | input | 8 | Target flash sector |
| req_all_sectors | input | 1 | All sectors are selected |
| req_from_app | input | 1 | Command is issued by the running application |
| boot_sel_n | input | 1 | Boot-select pin, active low |
| user_code_valid | input | 1 | Valid user code is present in sector 0 |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_allow | output | 1 | Command permitted |
| debug_disable | output | 1 | Debug port disabled |
| isp_entry | output | 1 | Entry into programming mode from the pin is permitted |
| level_o | output | 2 | Captured protection level |

## Verification
The bench powers the block up with each of the three magic words, with a word that differs from a magic word by one bit, and with zero. Under each level it sweeps all eight opcodes against sector 0 and a non-zero sector, with the all-sectors flag both low and high. This separates the sector rule from the erase rule and shows which opcodes each level denies. Write-RAM is tried one byte below the address floor and exactly at it, which tells a strict comparison from an inclusive one. Requests in the capture cycle, application-issued requests, rewrites of the word after capture, and every combination of boot pin and valid-code flag at level 3 and at level 0 check the remaining rules.

// File: rtl/crp_gate_pkg.sv
package crp_gate_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 32;
    localparam int SEC_W  = 8;

    localparam logic [WORD_W-1:0] KEY_LVL1 = 32'h1234_5678;
    localparam logic [WORD_W-1:0] KEY_LVL2 = 32'h8765_4321;
    localparam logic [WORD_W-1:0] KEY_LVL3 = 32'h4321_8765;

    typedef enum logic [1:0] {
        LVL_OPEN  = 2'd0,
        LVL_ONE   = 2'd1,
        LVL_TWO   = 2'd2,
        LVL_THREE = 2'd3
    } prot_lvl_e;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRAM  = 3'd1,
        OP_GO    = 3'd2,
        OP_COPY  = 3'd3,
        OP_CMP   = 3'd4,
        OP_ERASE = 3'd5,
        OP_OTHER = 3'd6,
        OP_SPARE = 3'd7
    } isp_op_e;

    typedef struct packed {
        isp_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [SEC_W-1:0]  sector;
        logic              all_sec;
        logic              from_app;
    } isp_cmd_t;

    function automatic prot_lvl_e decode_word(input logic [WORD_W-1:0] w);
        prot_lvl_e l;
        if (w == KEY_LVL1)      l = LVL_ONE;
        else if (w == KEY_LVL2) l = LVL_TWO;
        else if (w == KEY_LVL3) l = LVL_THREE;
        else                    l = LVL_OPEN;
        return l;
    endfunction

    function automatic logic judge_cmd(input prot_lvl_e lvl,
                                       input isp_cmd_t c,
                                       input logic [ADDR_W-1:0] ram_floor);
        logic ok;
        logic sec_zero;
        sec_zero = (c.sector == '0);
        ok = 1'b1;
        if (!c.from_app) begin
            unique case (lvl)
                LVL_ONE: begin
                    unique case (c.op)
                        OP_READ, OP_CMP: ok = 1'b0;
                        OP_WRAM:         ok = (c.addr >= ram_floor);
                        OP_COPY:         ok = !sec_zero;
                        OP_ERASE:        ok = !sec_zero || c.all_sec;
                        default:         ok = 1'b1;
                    endcase
                end
                LVL_TWO: begin
                    unique case (c.op)
                        OP_READ, OP_WRAM, OP_GO, OP_COPY, OP_CMP: ok = 1'b0;
                        OP_ERASE: ok = c.all_sec;
                        default:  ok = 1'b1;
                    endcase
                end
                default: ok = 1'b1;
            endcase
        end
        return ok;
    endfunction

endpackage

// File: rtl/crp_level_latch.sv
module crp_level_latch
    import crp_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] prot_word,
    output prot_lvl_e         level,
    output logic              sampled
);

    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= LVL_OPEN;
            sampled <= 1'b0;
        end else if (!sampled) begin
            level   <= decode_word(prot_word);
            sampled <= 1'b1;
        end
    end

    // R2: once captured, the level holds until the next reset
    p_level_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (sampled && $past(sampled)) |-> $stable(level));

    // R1: capture happens on the first edge out of reset and stays done
    p_capture_once_r1: assert property (@(posedge clk) disable iff (rst)
        $past(sampled) |-> sampled);

endmodule

// File: rtl/crp_cmd_judge.sv
module crp_cmd_judge
    import crp_gate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_FLOOR = 32'h4000_0200
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sampled,
    input  prot_lvl_e level,
    input  logic      req_valid,
    input  isp_cmd_t  cmd,
    output logic      resp_valid,
    output logic      resp_allow
);

    logic verdict;

    always_comb verdict = sampled && judge_cmd(level, cmd, RAM_FLOOR);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_allow <= req_valid && verdict;
        end
    end

    // R4: one response per request, one cycle later
    p_resp_follows_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);
    p_allow_gated_r4: assert property (@(posedge clk) disable iff (rst)
        resp_allow |-> resp_valid);

    // R5: nothing passes before the capture
    p_deny_early_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !sampled) |=> !resp_allow);

    // R9: level 2 never lets a read through
    p_lvl2_read_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && sampled && level == LVL_TWO && cmd.op == OP_READ
         && !cmd.from_app) |=> !resp_allow);

endmodule

// File: rtl/crp_cmd_gate.sv
module crp_cmd_gate
    import crp_gate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_FLOOR = 32'h4000_0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] prot_word,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SEC_W-1:0]  req_sector,
    input  logic              req_all_sectors,
    input  logic              req_from_app,
    input  logic              boot_sel_n,
    input  logic              user_code_valid,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic              debug_disable,
    output logic              isp_entry,
    output logic [1:0]        level_o
);

    prot_lvl_e level;
    logic      sampled;
    isp_cmd_t  cmd;

    always_comb begin
        cmd.op       = isp_op_e'(req_op);
        cmd.addr     = req_addr;
        cmd.sector   = req_sector;
        cmd.all_sec  = req_all_sectors;
        cmd.from_app = req_from_app;
    end

    crp_level_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .prot_word (prot_word),
        .level     (level),
        .sampled   (sampled)
    );

    crp_cmd_judge #(.RAM_FLOOR(RAM_FLOOR)) u_judge (
        .clk        (clk),
        .rst        (rst),
        .sampled    (sampled),
        .level      (level),
        .req_valid  (req_valid),
        .cmd        (cmd),
        .resp_valid (resp_valid),
        .resp_allow (resp_allow)
    );

    always_comb begin
        debug_disable = !sampled || (level != LVL_OPEN);
        isp_entry     = sampled && !boot_sel_n
                        && !(level == LVL_THREE && user_code_valid);
        level_o       = level;
    end

    // R3: any protection level keeps the debug port closed
    p_debug_closed_r3: assert property (@(posedge clk) disable iff (rst)
        (level_o != 2'd0) |-> debug_disable);

    // R10: level 3 with valid code blocks pin entry
    p_pin_block_r10: assert property (@(posedge clk) disable iff (rst)
        (level_o == 2'd3 && user_code_valid) |-> !isp_entry);

endmodule

// File: tb/crp_cmd_gate_tb.sv
module crp_cmd_gate_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] prot_word = 32'h0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_addr = 32'h0;
    logic [7:0]  req_sector = 8'd0;
    logic        req_all_sectors = 1'b0;
    logic        req_from_app = 1'b0;
    logic        boot_sel_n = 1'b1;
    logic        user_code_valid = 1'b0;
    logic        resp_valid, resp_allow, debug_disable, isp_entry;
    logic [1:0]  level_o;

    int total = 0;
    int bad = 0;

    // model state
    int  m_level = 0;
    bit  m_sampled = 0;
    bit  e_rv = 0;
    bit  e_ra = 0;

    always #2 clk = ~clk;

    crp_cmd_gate u_dut (
        .clk(clk), .rst(rst), .prot_word(prot_word),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_sector(req_sector), .req_all_sectors(req_all_sectors),
        .req_from_app(req_from_app), .boot_sel_n(boot_sel_n),
        .user_code_valid(user_code_valid),
        .resp_valid(resp_valid), .resp_allow(resp_allow),
        .debug_disable(debug_disable), .isp_entry(isp_entry),
        .level_o(level_o)
    );

    function automatic int ref_level(input logic [31:0] w);
        if (w == 32'h1234_5678) return 1;
        if (w == 32'h8765_4321) return 2;
        if (w == 32'h4321_8765) return 3;
        return 0;
    endfunction

    function automatic bit ref_allow(input int lv, input int op,
                                     input logic [31:0] a, input int sec,
                                     input bit all, input bit app);
        if (app || op >= 6) return 1;
        if (lv == 1) begin
            if (op == 0 || op == 4) return 0;
            if (op == 1) return a >= 32'h4000_0200;
            if (op == 3) return sec != 0;
            if (op == 5) return (sec != 0) || all;
            return 1;
        end
        if (lv == 2) begin
            if (op == 5) return all;
            return 0;
        end
        return 1;
    endfunction

    task automatic cycle(input string tag);
        bit e_dbg, e_ent;
        @(posedge clk);
        if (rst) begin
            e_rv = 0; e_ra = 0;
            m_sampled = 0; m_level = 0;
        end else begin
            e_rv = req_valid;
            e_ra = req_valid && m_sampled &&
                   ref_allow(m_level, int'(req_op), req_addr, int'(req_sector),
                             req_all_sectors, req_from_app);
            if (!m_sampled) begin
                m_level = ref_level(prot_word);
                m_sampled = 1;
            end
        end
        @(negedge clk);
        e_dbg = !m_sampled || (m_level != 0);
        e_ent = m_sampled && !boot_sel_n && !(m_level == 3 && user_code_valid);
        total++;
        if (resp_valid !== e_rv || resp_allow !== e_ra || debug_disable !== e_dbg
            || isp_entry !== e_ent || int'(level_o) != m_level) begin
            bad++;
            $display("FAIL %s: got rv=%0b ra=%0b dbg=%0b ent=%0b lvl=%0d exp rv=%0b ra=%0b dbg=%0b ent=%0b lvl=%0d",
                     tag, resp_valid, resp_allow, debug_disable, isp_entry, level_o,
                     e_rv, e_ra, e_dbg, e_ent, m_level);
        end
    endtask

    task automatic power_up(input logic [31:0] w, input string tag);
        rst = 1'b1;
        prot_word = w;
        cycle(tag);
        cycle(tag);
        rst = 1'b0;
        cycle(tag);
        prot_word = ~w;   // R2: later rewrite must not matter
        cycle("R2");
    endtask

    task automatic do_req(input string tag, input int op, input logic [31:0] a,
                          input int sec, input bit all, input bit app);
        req_valid = 1'b1;
        req_op = 3'(op);
        req_addr = a;
        req_sector = 8'(sec);
        req_all_sectors = all;
        req_from_app = app;
        cycle(tag);
        req_valid = 1'b0;
        cycle(tag);
    endtask

    task automatic sweep(input string tag);
        for (int op = 0; op < 8; op++)
            for (int s = 0; s < 2; s++)
                for (int al = 0; al < 2; al++)
                    do_req(tag, op, 32'h4000_1000, s * 3, bit'(al), 1'b0);
    endtask

    task automatic pins(input string tag);
        for (int b = 0; b < 2; b++)
            for (int v = 0; v < 2; v++) begin
                boot_sel_n = bit'(b);
                user_code_valid = bit'(v);
                cycle(tag);
            end
        boot_sel_n = 1'b1;
        user_code_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R3: reset state, debug closed and no response
        cycle("R3");
        // R5: request in the capture cycle is denied
        prot_word = 32'h0;
        req_valid = 1'b1; req_op = 3'd6; req_from_app = 1'b1;
        rst = 1'b0;
        cycle("R5");
        req_valid = 1'b0; req_from_app = 1'b0;
        cycle("R4");
        prot_word = 32'h1234_5678;
        cycle("R2");
        sweep("R11");
        pins("R10");

        // level 1
        power_up(32'h1234_5678, "R1");
        do_req("R6", 1, 32'h4000_01FF, 1, 0, 0);
        do_req("R6", 1, 32'h4000_0200, 1, 0, 0);
        do_req("R6", 1, 32'h0000_0000, 1, 0, 0);
        do_req("R7", 3, 32'h4000_1000, 0, 0, 0);
        do_req("R7", 3, 32'h4000_1000, 5, 0, 0);
        do_req("R8", 5, 32'h0, 0, 0, 0);
        do_req("R8", 5, 32'h0, 0, 1, 0);
        do_req("R11", 0, 32'h0, 0, 0, 1);
        sweep("R8");
        pins("R10");

        // back-to-back requests
        req_valid = 1'b1; req_op = 3'd0; req_from_app = 1'b0;
        cycle("R4");
        req_op = 3'd2;
        cycle("R4");
        req_valid = 1'b0;
        cycle("R4");

        // level 2
        power_up(32'h8765_4321, "R1");
        sweep("R9");
        do_req("R11", 4, 32'h0, 0, 0, 1);
        pins("R10");

        // level 3
        power_up(32'h4321_8765, "R1");
        sweep("R11");
        pins("R10");

        // near-miss word gives no protection
        power_up(32'h1234_5679, "R1");
        sweep("R11");
        pins("R3");

        // reset mid-request
        req_valid = 1'b1; req_op = 3'd6;
        rst = 1'b1;
        cycle("R4");
        req_valid = 1'b0;
        cycle("R4");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule